// File: doc/BRIEF.md
# Sequential Non-Restoring Unsigned Divider

This block divides one unsigned integer by another, one quotient bit per clock, with a single adder/subtractor that is reused every cycle. Each operation picks either a narrow (32-bit) or a wide (64-bit) width. A request is a one-cycle `start_i` while the unit is idle. The unit then raises `busy_o` and ignores further requests until the result is ready.

On each iteration the unit either adds or subtracts the divisor, chosen by the sign of the partial remainder. No restore step is ever taken. Quotient digits are +1 or −1 and are held as 1 or 0 in the same shift register that feeds dividend bits into the remainder. After the last iteration the digit pattern is converted to plain binary. A negative remainder is then corrected with one add of the divisor, and the quotient is reduced by one.

Setup and correction cycles pad the run so that the completion pulse always arrives a fixed number of cycles after the request: 35 in narrow mode and 67 in wide mode. A zero divisor does not trap. It completes on the same schedule and raises a flag.

Top module: `nrd_divider`

## Requirements
- R1: A `start_i` seen at a clock edge while `busy_o` is low is accepted. `busy_o` is high from the next cycle and stays high until the cycle in which `done_o` rises.
- R2: `done_o` is a single-cycle pulse. It is high in the cycle that begins 67 clock edges after the accepting edge when `wide_i` was 1, and 35 edges after when `wide_i` was 0. `busy_o` is low in that same cycle.
- R3: In wide mode (`wide_i`=1) with a nonzero divisor, `quotient_o` is the 64-bit unsigned floor of dividend/divisor. `remainder_o` is dividend − quotient·divisor and is smaller than the divisor.
- R4: In narrow mode (`wide_i`=0) only bits 31:0 of both operands are used. `quotient_o` and `remainder_o` are the 32-bit results, with bits 63:32 zero.
- R5: A `start_i` seen while `busy_o` is high is ignored. The running operation completes on its own schedule with the operands and mode that were accepted.
- R6: A divisor of zero (within the mode width) sets `div0_o` together with `done_o`. In that case `quotient_o` is all ones over the mode width and `remainder_o` equals the mode-width dividend. For a nonzero divisor, `div0_o` is 0.
- R7: `quotient_o`, `remainder_o` and `div0_o` change only at the edge that raises `done_o`. They hold their values in all other cycles.
- R8: While reset is asserted, `busy_o`, `done_o`, `quotient_o`, `remainder_o` and `div0_o` are all zero.
- R9: A `start_i` presented in the cycle in which `done_o` is high is accepted, so operations can run back to back with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a division; accepted only while idle |
| wide_i | input | 1 | 1 selects the 64-bit mode, 0 the 32-bit mode; sampled with start |
| dividend_i | input | 64 | Dividend, sampled at the accepting edge |
| divisor_i | input | 64 | Divisor, sampled at the accepting edge |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quotient_o | output | 64 | Quotient of the last completed operation |
| remainder_o | output | 64 | Remainder of the last completed operation |
| div0_o | output | 1 | Last completed operation had a zero divisor |

## Verification
The assertions treat `start_i` as a level that is sampled at every edge. Any high value seen while idle is therefore a fresh request, and the latency counter restarts from it. They also expect reset to be held across at least one edge, so that captured operands and counters start from known values. The stimulus changes inputs only on the falling edge and holds `start_i` high for a single cycle per request. It also deliberately raises `start_i` during a running operation and in the completion cycle, so that the ignore rule and the back-to-back rule are both exercised.

// File: rtl/nrd_pkg.sv
package nrd_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_SETUP,
      PH_ITER,
      PH_CONV,
      PH_FIX
   } nrd_phase_e;

   // setup cycle + one cycle per quotient bit + conversion + correction
   localparam int unsigned NRD_PAD_CYCLES = 3;

   function automatic int unsigned nrd_latency(input int unsigned bits);
      return bits + NRD_PAD_CYCLES;
   endfunction

endpackage

// File: rtl/nrd_seq.sv
module nrd_seq
   import nrd_pkg::*;
#(
   parameter int unsigned WIDE_W   = 64,
   parameter int unsigned NARROW_W = 32
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       wide_i,
   output logic       accept_o,
   output logic       busy_o,
   output nrd_phase_e phase_o
);

   localparam int unsigned SW = $clog2(nrd_latency(WIDE_W));

   logic          busy_q;
   logic [SW-1:0] step_q;
   logic [SW-1:0] iter_q;

   assign accept_o = start_i && !busy_q;
   assign busy_o   = busy_q;

   always_comb begin
      if (!busy_q)                        phase_o = PH_IDLE;
      else if (step_q == '0)              phase_o = PH_SETUP;
      else if (step_q <= iter_q)          phase_o = PH_ITER;
      else if (step_q == iter_q + SW'(1)) phase_o = PH_CONV;
      else                                phase_o = PH_FIX;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         step_q <= '0;
         iter_q <= '0;
      end else if (accept_o) begin
         busy_q <= 1'b1;
         step_q <= '0;
         iter_q <= wide_i ? SW'(WIDE_W) : SW'(NARROW_W);
      end else if (busy_q) begin
         if (phase_o == PH_FIX) begin
            busy_q <= 1'b0;
            step_q <= '0;
         end else begin
            step_q <= step_q + SW'(1);
         end
      end
   end

endmodule

// File: rtl/nrd_addsub.sv
module nrd_addsub #(
   parameter int unsigned W = 64
) (
   input  logic [W+1:0] acc_i,
   input  logic         next_bit_i,
   input  logic [W-1:0] dv_i,
   output logic [W+1:0] acc_o,
   output logic         digit_o
);

   logic [W+1:0] doubled;
   logic [W+1:0] dv_ext;

   assign doubled = {acc_i[W:0], next_bit_i};
   assign dv_ext  = {2'b00, dv_i};
   // digit +1 (stored 1) when the remainder is not negative, else -1 (stored 0)
   assign digit_o = ~acc_i[W+1];
   assign acc_o   = digit_o ? (doubled - dv_ext) : (doubled + dv_ext);

endmodule

// File: rtl/nrd_fixup.sv
module nrd_fixup #(
   parameter int unsigned WIDE_W   = 64,
   parameter int unsigned NARROW_W = 32
) (
   input  logic              wide_i,
   input  logic [WIDE_W-1:0] qd_i,
   input  logic              rem_neg_i,
   input  logic [WIDE_W-1:0] rem_low_i,
   input  logic [WIDE_W-1:0] dv_i,
   output logic [WIDE_W-1:0] conv_o,
   output logic [WIDE_W-1:0] quot_o,
   output logic [WIDE_W-1:0] rem_o
);

   logic [WIDE_W-1:0] mode_mask;
   logic [WIDE_W-1:0] conv_raw;
   logic [WIDE_W-1:0] quot_raw;

   generate
      if (NARROW_W < WIDE_W) begin : g_split_mask
         localparam logic [WIDE_W-1:0] NMASK =
            {{(WIDE_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
         assign mode_mask = wide_i ? '1 : NMASK;
      end else begin : g_full_mask
         assign mode_mask = '1;
      end
   endgenerate

   // positive digits minus negative digits (ones' complement of the pattern)
   assign conv_raw = qd_i - ~qd_i;
   assign conv_o   = conv_raw & mode_mask;

   assign quot_raw = rem_neg_i ? (qd_i - WIDE_W'(1)) : qd_i;
   assign quot_o   = quot_raw & mode_mask;
   assign rem_o    = rem_neg_i ? (rem_low_i + dv_i) : rem_low_i;

endmodule

// File: rtl/nrd_divider.sv
module nrd_divider
   import nrd_pkg::*;
#(
   parameter int unsigned WIDE_W   = 64,
   parameter int unsigned NARROW_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              wide_i,
   input  logic [WIDE_W-1:0] dividend_i,
   input  logic [WIDE_W-1:0] divisor_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [WIDE_W-1:0] quotient_o,
   output logic [WIDE_W-1:0] remainder_o,
   output logic              div0_o
);

   localparam int unsigned GAP = WIDE_W - NARROW_W;
   localparam logic [WIDE_W-1:0] NMASK =
      {{GAP{1'b0}}, {NARROW_W{1'b1}}};

   generate
      if (NARROW_W < 2 || NARROW_W >= WIDE_W) begin : g_bad_widths
         $error("nrd_divider: NARROW_W must be at least 2 and below WIDE_W");
      end
   endgenerate

   nrd_phase_e        phase;
   logic              accept;
   logic              wide_q;
   logic [WIDE_W-1:0] dv_q;
   logic [WIDE_W+1:0] acc_q;
   logic [WIDE_W-1:0] qd_q;
   logic              zero_q;
   logic [WIDE_W-1:0] quot_q;
   logic [WIDE_W-1:0] rem_q;
   logic              div0_q;
   logic              done_q;

   logic [WIDE_W+1:0] acc_nx;
   logic              digit;
   logic [WIDE_W-1:0] conv_q;
   logic [WIDE_W-1:0] fix_q;
   logic [WIDE_W-1:0] fix_r;
   logic [WIDE_W-1:0] load_qd;

   nrd_seq #(
      .WIDE_W  (WIDE_W),
      .NARROW_W(NARROW_W)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .wide_i  (wide_i),
      .accept_o(accept),
      .busy_o  (busy_o),
      .phase_o (phase)
   );

   nrd_addsub #(
      .W(WIDE_W)
   ) u_addsub (
      .acc_i     (acc_q),
      .next_bit_i(qd_q[WIDE_W-1]),
      .dv_i      (dv_q),
      .acc_o     (acc_nx),
      .digit_o   (digit)
   );

   nrd_fixup #(
      .WIDE_W  (WIDE_W),
      .NARROW_W(NARROW_W)
   ) u_fixup (
      .wide_i   (wide_q),
      .qd_i     (qd_q),
      .rem_neg_i(acc_q[WIDE_W+1]),
      .rem_low_i(acc_q[WIDE_W-1:0]),
      .dv_i     (dv_q),
      .conv_o   (conv_q),
      .quot_o   (fix_q),
      .rem_o    (fix_r)
   );

   // narrow operands sit at the top of the shift register so their
   // most significant bit is the first one shifted into the remainder
   assign load_qd = wide_i ? dividend_i : (dividend_i << GAP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wide_q <= 1'b0;
         dv_q   <= '0;
         acc_q  <= '0;
         qd_q   <= '0;
         zero_q <= 1'b0;
         quot_q <= '0;
         rem_q  <= '0;
         div0_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (phase)
            PH_IDLE: begin
               if (accept) begin
                  wide_q <= wide_i;
                  dv_q   <= wide_i ? divisor_i : (divisor_i & NMASK);
                  qd_q   <= load_qd;
                  acc_q  <= '0;
               end
            end
            PH_SETUP: begin
               zero_q <= (dv_q == '0);
            end
            PH_ITER: begin
               acc_q <= acc_nx;
               qd_q  <= {qd_q[WIDE_W-2:0], digit};
            end
            PH_CONV: begin
               qd_q <= conv_q;
            end
            PH_FIX: begin
               quot_q <= fix_q;
               rem_q  <= fix_r;
               div0_q <= zero_q;
               done_q <= 1'b1;
            end
            default: ;
         endcase
      end
   end

   assign done_o      = done_q;
   assign quotient_o  = quot_q;
   assign remainder_o = rem_q;
   assign div0_o      = div0_q;

endmodule

// File: rtl/nrd_chk.sv
module nrd_chk #(
   parameter int unsigned WIDE_W   = 64,
   parameter int unsigned NARROW_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              wide_i,
   input logic              busy_o,
   input logic              done_o,
   input logic [WIDE_W-1:0] quotient_o,
   input logic [WIDE_W-1:0] remainder_o,
   input logic              div0_o,
   input logic              wide_q,
   input logic [WIDE_W-1:0] dv_q
);

   logic [15:0] run_cnt;
   logic [15:0] run_lat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt <= '0;
         run_lat <= '0;
      end else if (start_i && !busy_o) begin
         run_cnt <= '0;
         run_lat <= wide_i ? 16'(WIDE_W + 3) : 16'(NARROW_W + 3);
      end else if (busy_o) begin
         run_cnt <= run_cnt + 16'd1;
      end
   end

   a_r1_busy_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !busy_o |=> busy_o);

   a_r1_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> busy_o || done_o);

   a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r2_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> run_cnt == run_lat);

   a_r2_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   a_r3_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && !div0_o |-> remainder_o < dv_q);

   a_r4_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && !wide_q |-> (quotient_o >> NARROW_W) == '0 && (remainder_o >> NARROW_W) == '0);

   a_r5_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && start_i |=> $stable(dv_q) && $stable(wide_q));

   a_r6_flag_zero_divisor: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> div0_o == (dv_q == '0));

   a_r7_results_held: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(quotient_o) && $stable(remainder_o) && $stable(div0_o));

endmodule

bind nrd_divider nrd_chk #(
   .WIDE_W  (WIDE_W),
   .NARROW_W(NARROW_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .wide_i     (wide_i),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .quotient_o (quotient_o),
   .remainder_o(remainder_o),
   .div0_o     (div0_o),
   .wide_q     (wide_q),
   .dv_q       (dv_q)
);

// File: tb/nrd_divider_tb.sv
module nrd_divider_tb;

   localparam int unsigned W = 64;
   localparam int unsigned N = 32;
   localparam time CLK_PERIOD = 10;
   localparam logic [63:0] NMASK = 64'h0000_0000_FFFF_FFFF;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          wide = 1'b0;
   logic [W-1:0]  dvd = '0;
   logic [W-1:0]  dvs = '0;
   logic          busy, done, div0;
   logic [W-1:0]  quot, rem;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   // reference model state
   int          m_cnt = 0;
   bit          m_done = 0;
   logic [63:0] m_q = '0, m_r = '0;
   bit          m_z = 0, m_wide = 0;
   logic [63:0] p_q, p_r;
   bit          p_z, p_wide;

   always #(CLK_PERIOD/2) clk = ~clk;

   nrd_divider #(.WIDE_W(W), .NARROW_W(N)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start),
      .wide_i     (wide),
      .dividend_i (dvd),
      .divisor_i  (dvs),
      .busy_o     (busy),
      .done_o     (done),
      .quotient_o (quot),
      .remainder_o(rem),
      .div0_o     (div0)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic void ref_div(input bit w, input logic [63:0] x, input logic [63:0] y,
                                   output logic [63:0] q, output logic [63:0] r, output bit z);
      logic [63:0] xa, ya;
      xa = w ? x : (x & NMASK);
      ya = w ? y : (y & NMASK);
      z = (ya == 64'd0);
      if (z) begin
         q = w ? '1 : NMASK;
         r = xa;
      end else begin
         q = xa / ya;
         r = xa % ya;
      end
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_done = 0; m_q = '0; m_r = '0; m_z = 0; m_wide = 0;
      end else begin
         m_done = 0;
         if (m_cnt == 0 && start) begin
            ref_div(wide, dvd, dvs, p_q, p_r, p_z);
            p_wide = wide;
            m_cnt = wide ? W + 3 : N + 3;
         end else if (m_cnt > 0) begin
            m_cnt--;
            if (m_cnt == 0) begin
               m_done = 1; m_q = p_q; m_r = p_r; m_z = p_z; m_wide = p_wide;
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         string rq;
         rq = m_z ? "R6" : (m_wide ? "R3" : "R4");
         if (!m_done) rq = "R7";
         check("R1 busy", {63'd0, busy}, {63'd0, m_cnt > 0});
         check("R2 done", {63'd0, done}, {63'd0, m_done});
         check({rq, " quotient"}, quot, m_q);
         check({rq, " remainder"}, rem, m_r);
         check("R6 flag", {63'd0, div0}, {63'd0, m_z});
      end
   end

   task automatic wait_done();
      for (int i = 0; i < 100 && done !== 1'b1; i++) @(negedge clk);
   endtask

   task automatic op(input bit w, input logic [63:0] x, input logic [63:0] y);
      @(negedge clk);
      start = 1'b1; wide = w; dvd = x; dvs = y;
      @(negedge clk);
      start = 1'b0;
      wait_done();
   endtask

   task automatic finish_up();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog expired actual=running expected=finished");
         finish_up();
      end
   end

   initial begin
      logic [63:0] eq, er;
      bit ez;
      repeat (3) @(negedge clk);
      // R8: outputs at rest while reset is held
      check("R8 busy", {63'd0, busy}, 64'd0);
      check("R8 done", {63'd0, done}, 64'd0);
      check("R8 quotient", quot, 64'd0);
      check("R8 remainder", rem, 64'd0);
      check("R8 flag", {63'd0, div0}, 64'd0);
      rst_n = 1'b1;

      // R3: wide mode patterns
      op(1, 64'd100, 64'd7);
      op(1, '1, 64'd1);
      op(1, '1, '1);
      op(1, 64'd5, 64'hFFFF_0000_0000_0000);
      op(1, 64'h8000_0000_0000_0000, 64'd3);
      op(1, 64'd0, 64'd9);
      // R4: narrow mode with garbage in the upper operand bits
      op(0, 64'hDEAD_BEEF_0000_0064, 64'h1234_5678_0000_0007);
      op(0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hAAAA_AAAA_0000_0001);
      op(0, 64'h0000_0001_FFFF_FFFF, 64'h0000_0000_8000_0000);
      // R6: zero divisor, both modes; narrow one has a nonzero upper divisor half
      op(1, 64'h0123_4567_89AB_CDEF, 64'd0);
      op(0, 64'hCAFE_0000_1357_9BDF, 64'hFFFF_FFFF_0000_0000);

      // R5: a second request in the middle of a run is ignored
      ref_div(1, 64'd1_000_003, 64'd17, eq, er, ez);
      @(negedge clk);
      start = 1'b1; wide = 1'b1; dvd = 64'd1_000_003; dvs = 64'd17;
      @(negedge clk);
      start = 1'b0;
      repeat (10) @(negedge clk);
      start = 1'b1; wide = 1'b0; dvd = 64'd99; dvs = 64'd4;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      check("R5 quotient", quot, eq);
      check("R5 remainder", rem, er);

      // R9: request presented in the completion cycle is taken
      start = 1'b1; wide = 1'b0; dvd = 64'd1000; dvs = 64'd33;
      @(negedge clk);
      start = 1'b0;
      check("R9 busy", {63'd0, busy}, 64'd1);
      wait_done();

      // R7: results hold while inputs move without a request
      ref_div(0, 64'd1000, 64'd33, eq, er, ez);
      dvd = '1; dvs = 64'd2;
      repeat (5) @(negedge clk);
      check("R7 quotient", quot, eq);
      check("R7 remainder", rem, er);

      // random operands in both modes
      for (int k = 0; k < 24; k++) begin
         logic [63:0] x, y;
         x = {$urandom, $urandom};
         y = {$urandom, $urandom} >> ($urandom % 64);
         op(k[0], x, y);
      end

      repeat (3) @(negedge clk);
      finish_up();
   end

endmodule